// File: doc/BRIEF.md
# Global Error Toggle Handshake Register

This block keeps two registers of equal width: an error record and a software acknowledge copy. A bit is outstanding whenever the two copies disagree. Internal sources report faults by presenting a request mask. The block flips the record bits named by the request, but only those bits that are not already outstanding. Software clears a fault by writing the acknowledge copy so that the bit matches the record again.

The block drives a single-cycle error interrupt when a new fault is recorded and the interrupt enable input is high. It exports the outstanding vector and a halt flag taken from the command-queue fault bit. Every acknowledge write also produces a one-cycle kick, so the command consumer can retry once its fault is cleared. A debug pulse shows when an acknowledge write flips a bit that was not outstanding. Four 32-bit interrupt routing words are held for software and have no effect on the block's outputs.

Register map on the port (word index): 0 error record (read only), 1 acknowledge copy, 2 to 5 routing words, 6 and 7 read as zero.

Top module: `gerr_toggle_ack`

## Requirements
- R1: After reset the error record, the acknowledge copy and every routing word read as zero. The outstanding vector is zero and no pulse output is high.
- R2: The outstanding vector always equals the error record XOR the acknowledge copy, both as read from the port at words 0 and 1.
- R3: A request mask flips, at the next clock edge, exactly the requested bits that are not outstanding. Requested bits that are already outstanding keep their record value.
- R4: errIrq is high for exactly one cycle after an edge at which at least one new bit was recorded, and only when irqEnable was high at that edge.
- R5: A write to word 1 stores all W data bits into the acknowledge copy. strayAck pulses for one cycle when that write flips any bit that was not outstanding.
- R6: cmdqHalt is high exactly while bit CMDQ_BIT of the outstanding vector is set.
- R7: Every write to word 1 produces a one-cycle cmdqKick pulse in the following cycle.
- R8: A request and an acknowledge write in the same cycle both take effect. The request is judged against the outstanding vector from before that edge.
- R9: Words 2 to 5 store and return full 32-bit values and do not change the outstanding vector or any pulse output.
- R10: Writes to word 0 are ignored: the record and the outstanding vector are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| raiseMask | input | W | Fault request mask from internal sources |
| irqEnable | input | 1 | Error interrupt enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write word index |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 3 | Register read word index |
| rdData | output | DATA_W | Register read data (combinational) |
| pendingVec | output | W | Outstanding fault bits |
| cmdqHalt | output | 1 | Command-queue fault outstanding |
| errIrq | output | 1 | One-cycle error interrupt pulse |
| cmdqKick | output | 1 | One-cycle retry pulse after an acknowledge write |
| strayAck | output | 1 | One-cycle debug pulse for a non-outstanding flip |

## Verification
Register contents, the outstanding vector and cmdqHalt change at the edge that takes the request or write. The bench therefore samples them one time step after that edge, with rdData sampled one step after rdAddr settles. errIrq, cmdqKick and strayAck come from one register stage, so they are high in the cycle that starts at that same edge. The bench samples them there, and then once more after the next edge to confirm they have dropped. A bench model of both registers is advanced at each edge from the values before the edge, and every expected value comes from that model.

// File: rtl/gerr_pkg.sv
package gerr_pkg;
  localparam int GERR_CFG_WORDS = 4;
  localparam int GERR_ADDR_W = 3;
  localparam logic [GERR_ADDR_W-1:0] ADDR_ERR = 3'd0;
  localparam logic [GERR_ADDR_W-1:0] ADDR_ACK = 3'd1;
  localparam logic [GERR_ADDR_W-1:0] ADDR_CFG0 = 3'd2;

  typedef struct packed {
    logic                      ackWr;
    logic [GERR_CFG_WORDS-1:0] cfgWr;
  } gerr_strobe_t;
endpackage

// File: rtl/gerr_ctrl.sv
module gerr_ctrl
  import gerr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [GERR_ADDR_W-1:0] wrAddr,
  input  logic                   irqEnable,
  input  logic                   newErrAny,
  input  logic                   strayAny,
  output gerr_strobe_t           strobes,
  output logic                   errIrq,
  output logic                   cmdqKick,
  output logic                   strayAck
);
  always_comb begin
    strobes.ackWr = wrEn && (wrAddr == ADDR_ACK);
    for (int k = 0; k < GERR_CFG_WORDS; k++) begin
      strobes.cfgWr[k] = wrEn && (wrAddr == ADDR_CFG0 + GERR_ADDR_W'(k));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errIrq   <= 1'b0;
      cmdqKick <= 1'b0;
      strayAck <= 1'b0;
    end else begin
      errIrq   <= newErrAny && irqEnable;
      cmdqKick <= strobes.ackWr;
      strayAck <= strobes.ackWr && strayAny;
    end
  end
endmodule

// File: rtl/gerr_datapath.sv
module gerr_datapath
  import gerr_pkg::*;
#(
  parameter int W = 32,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  gerr_strobe_t           strobes,
  input  logic [W-1:0]           raiseMask,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [GERR_ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]      rdData,
  output logic [W-1:0]           pendingVec,
  output logic                   newErrAny,
  output logic                   strayAny
);
  logic [W-1:0] errReg, ackReg, newErr, ackIn;
  logic [DATA_W-1:0] cfgReg [GERR_CFG_WORDS];

  assign pendingVec = errReg ^ ackReg;
  assign newErr     = raiseMask & ~pendingVec;
  assign newErrAny  = |newErr;
  assign ackIn      = wrData[W-1:0];
  assign strayAny   = |((ackReg ^ ackIn) & ~pendingVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errReg <= '0;
      ackReg <= '0;
    end else begin
      errReg <= errReg ^ newErr;
      if (strobes.ackWr) ackReg <= ackIn;
    end
  end

  for (genvar g = 0; g < GERR_CFG_WORDS; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgReg[g] <= '0;
      else if (strobes.cfgWr[g]) cfgReg[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_ERR) rdData[W-1:0] = errReg;
    if (rdAddr == ADDR_ACK) rdData[W-1:0] = ackReg;
    for (int k = 0; k < GERR_CFG_WORDS; k++) begin
      if (rdAddr == ADDR_CFG0 + GERR_ADDR_W'(k)) rdData = cfgReg[k];
    end
  end
endmodule

// File: rtl/gerr_toggle_ack.sv
module gerr_toggle_ack
  import gerr_pkg::*;
#(
  parameter int W = 32,
  parameter int DATA_W = 32,
  parameter int CMDQ_BIT = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [W-1:0]           raiseMask,
  input  logic                   irqEnable,
  input  logic                   wrEn,
  input  logic [GERR_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [GERR_ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]      rdData,
  output logic [W-1:0]           pendingVec,
  output logic                   cmdqHalt,
  output logic                   errIrq,
  output logic                   cmdqKick,
  output logic                   strayAck
);
  gerr_strobe_t strobes;
  logic newErrAny, strayAny;

  gerr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .irqEnable(irqEnable), .newErrAny(newErrAny), .strayAny(strayAny),
    .strobes(strobes), .errIrq(errIrq), .cmdqKick(cmdqKick),
    .strayAck(strayAck)
  );

  gerr_datapath #(.W(W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .raiseMask(raiseMask),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .pendingVec(pendingVec), .newErrAny(newErrAny), .strayAny(strayAny)
  );

  assign cmdqHalt = pendingVec[CMDQ_BIT];
endmodule

// File: rtl/gerr_checker.sv
module gerr_checker #(
  parameter int W = 32,
  parameter int CMDQ_BIT = 0
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] raiseMask,
  input logic         irqEnable,
  input logic         wrEn,
  input logic [2:0]   wrAddr,
  input logic [W-1:0] pendingVec,
  input logic         cmdqHalt,
  input logic         errIrq,
  input logic         cmdqKick
);
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> !errIrq || $past(irqEnable));

  p_irq_needs_new_r4: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> ($past(irqEnable) && (($past(raiseMask) & ~$past(pendingVec)) != '0)));

  p_kick_after_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd1) |=> cmdqKick);

  p_no_clear_without_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 3'd1) |=> ((pendingVec & $past(pendingVec)) == $past(pendingVec)));

  p_quiet_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (raiseMask == '0 && !(wrEn && wrAddr == 3'd1)) |=> $stable(pendingVec));

  p_halt_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(raiseMask[CMDQ_BIT]) && !$past(pendingVec[CMDQ_BIT]) && !$past(wrEn && wrAddr == 3'd1)) |-> cmdqHalt);
endmodule

bind gerr_toggle_ack gerr_checker #(.W(W), .CMDQ_BIT(CMDQ_BIT)) u_gerr_checker (
  .clk(clk), .rstN(rstN), .raiseMask(raiseMask), .irqEnable(irqEnable),
  .wrEn(wrEn), .wrAddr(wrAddr), .pendingVec(pendingVec), .cmdqHalt(cmdqHalt),
  .errIrq(errIrq), .cmdqKick(cmdqKick)
);

// File: tb/gerr_toggle_ack_bench.sv
`timescale 1ns/1ps
module gerr_toggle_ack_bench;
  localparam int W = 8;
  localparam int DW = 32;
  localparam int CB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] raiseMask = '0;
  logic irqEnable = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [W-1:0] pendingVec;
  logic cmdqHalt, errIrq, cmdqKick, strayAck;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] mErr = '0, mAck = '0;
  logic eIrq = 0, eKick = 0, eStray = 0;

  always #5 clk = ~clk;

  gerr_toggle_ack #(.W(W), .DATA_W(DW), .CMDQ_BIT(CB)) u_gerr_toggle_ack (
    .clk(clk), .rstN(rstN), .raiseMask(raiseMask), .irqEnable(irqEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .pendingVec(pendingVec), .cmdqHalt(cmdqHalt),
    .errIrq(errIrq), .cmdqKick(cmdqKick), .strayAck(strayAck)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readChk(string req, logic [2:0] a, logic [DW-1:0] exp);
    rdAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  // one clock step; model advanced from pre-edge values
  task automatic step(logic [W-1:0] rm, logic en, logic we, logic [2:0] wa, logic [DW-1:0] wd);
    logic [W-1:0] pend;
    pend = mErr ^ mAck;
    raiseMask = rm; irqEnable = en; wrEn = we; wrAddr = wa; wrData = wd;
    eIrq = en && ((rm & ~pend) != '0);
    eKick = we && wa == 3'd1;
    eStray = eKick && (((mAck ^ wd[W-1:0]) & ~pend) != '0);
    mErr = mErr ^ (rm & ~pend);
    if (eKick) mAck = wd[W-1:0];
    @(posedge clk);
    #1;
    raiseMask = '0; wrEn = 1'b0;
  endtask

  task automatic checkAll();
    chk("R2 pending", DW'(pendingVec), DW'(mErr ^ mAck));
    chk("R6 halt", DW'(cmdqHalt), DW'((mErr[CB] ^ mAck[CB])));
    chk("R4 irq", DW'(errIrq), DW'(eIrq));
    chk("R7 kick", DW'(cmdqKick), DW'(eKick));
    chk("R5 stray", DW'(strayAck), DW'(eStray));
    readChk("R3 errReg", 3'd0, DW'(mErr));
    readChk("R5 ackReg", 3'd1, DW'(mAck));
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    for (int a = 0; a < 8; a++) readChk("R1 reset read", 3'(a), '0);
    chk("R1 pending", DW'(pendingVec), '0);
    chk("R1 pulses", DW'({errIrq, cmdqKick, strayAck}), '0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R3/R4 exhaustive raise sweep, irq enable alternating, no acks
    for (int i = 0; i < 256; i++) begin
      step(W'(i), i[0], 1'b0, 3'd0, '0);
      checkAll();
    end
    // R4 pulse drops after a quiet cycle
    step('0, 1'b1, 1'b0, 3'd0, '0);
    checkAll();

    // R5/R7/R6 acknowledge sweep over all values
    for (int i = 0; i < 256; i++) begin
      step('0, 1'b1, 1'b1, 3'd1, DW'((i * 37 + 11) & 8'hFF) | 32'hA5A5_0000);
      checkAll();
    end

    // R8 simultaneous raise and ack sweep
    for (int i = 0; i < 256; i++) begin
      step(W'(i * 13 + 7), 1'b1, 1'b1, 3'd1, DW'((i * 91) & 8'hFF));
      checkAll();
    end

    // R10 writes to word 0 ignored
    step('0, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF);
    checkAll();
    readChk("R10 err unchanged", 3'd0, DW'(mErr));

    // R9 routing words store, no effect on outputs
    for (int k = 0; k < 4; k++) begin
      step('0, 1'b1, 1'b1, 3'(k + 2), 32'hC0DE_0000 + 32'(k * 4369));
      checkAll();
    end
    for (int k = 0; k < 4; k++) readChk("R9 cfg readback", 3'(k + 2), 32'hC0DE_0000 + 32'(k * 4369));
    readChk("R9 unused word", 3'd6, '0);

    // R6 explicit halt set then clear
    step('0, 1'b0, 1'b1, 3'd1, DW'(mErr));
    checkAll();
    chk("R6 halt cleared", DW'(cmdqHalt), '0);
    step(W'(1 << CB), 1'b0, 1'b0, 3'd0, '0);
    checkAll();
    chk("R6 halt set", DW'(cmdqHalt), 32'd1);
    step('0, 1'b0, 1'b1, 3'd1, DW'(mErr));
    checkAll();
    chk("R7 kick on clear", DW'(cmdqKick), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule